// File: doc/BRIEF.md
# Burst-Limited Edge Sampler with Two-Bank Write Pointer

The block watches a slow external strobe and samples a parallel data word on each rising edge of it. Both the strobe and an external re-arm line are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and a rising edge is found by comparing the synchronized level with its value one clock earlier. Every accepted edge produces one write on a memory write port. The address on that port is a bank select bit above an offset within the bank. The memory behind the port is split into two equal banks and is used as a ping-pong buffer.

A burst holds exactly `BURST_LEN` captures, 192 by default. When a burst is complete the block goes idle and drops strobe edges until the re-arm line shows a rising edge. The write pointer is never rewound between bursts. A new burst continues at the location after the last one written. When the pointer leaves the last offset of a bank, the block pulses a flag for that bank and moves on to the other bank. After bank 1 it wraps to bank 0. A single-cycle burst-done pulse marks the last write of each burst.

The system clock must be several times faster than the strobe. The strobe must stay high for at least three system clocks and low for at least three. The data word must stay stable from the strobe's rising edge until three system clocks later.

Top module: `burst_sampler`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `wr_en_o`, `burst_done_o` and `bank_full_o` are 0. After reset the block is armed and the write pointer is at bank 0, offset 0, so the first accepted strobe edge writes address 0.
- R2: While a burst is active, each rising edge of `samp_i` causes exactly one cycle of `wr_en_o`. In that cycle `wr_data_o` equals the `data_i` value held across the edge.
- R3: A burst ends after exactly `BURST_LEN` (192) writes. Later strobe edges cause no write until a re-arm.
- R4: `burst_done_o` is high for one cycle, in the same cycle as the last write of a burst, and at no other time.
- R5: A rising edge of `rearm_i` while the block is idle starts a new burst of `BURST_LEN` writes.
- R6: `wr_addr_o` is `{bank, offset}`, with the bank in the MSB and the offset in the low `log2(BANK_DEPTH)` bits. Successive writes step the address by one, including across bursts. A re-arm does not rewind the pointer.
- R7: A write to offset `BANK_DEPTH-1` raises `bank_full_o[bank]` in the same cycle, and no more than one bit of `bank_full_o` is ever high. The write after offset `BANK_DEPTH-1` of bank 1 goes to address 0.
- R8: A rising edge of `rearm_i` during an active burst has no effect. That burst still ends after exactly `BURST_LEN` writes in total.
- R9: A strobe held high for many cycles produces a single write, and its falling edge produces none.
- R10: A reset in the middle of a burst returns the pointer to address 0 and starts a fresh burst of `BURST_LEN` writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_i | input | 1 | Asynchronous sampling strobe; its rising edges trigger captures |
| rearm_i | input | 1 | Asynchronous re-arm; a rising edge while idle starts a burst |
| data_i | input | DATA_W | Parallel word captured on each strobe edge |
| wr_en_o | output | 1 | Memory write enable, one cycle per capture |
| wr_addr_o | output | log2(BANK_DEPTH)+1 | Write address: bank bit in MSB, offset below it |
| wr_data_o | output | DATA_W | Captured word |
| bank_full_o | output | 2 | One-cycle flag for the bank whose last offset was just written |
| burst_done_o | output | 1 | One-cycle flag on the final write of a burst |

## Verification
The hardest situation to reach is a burst that fills one bank, spills into the other and then wraps from the top of bank 1 back to address 0. The pointer never rewinds, so these boundaries are only reached after several complete bursts. The bench therefore runs three full bursts in a row, with re-arms between them, and strobe high and low times drawn at random. Two corner cases are placed directly in that sequence: a re-arm in the middle of the first burst, and an unusually long strobe high time. A reset in the middle of a burst then checks that the pointer starts again from address 0.

// File: rtl/burst_pkg.sv
// Shared types for the burst sampler.
// Assumes: exactly two banks, selected by a single bit above the offset.
package burst_pkg;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/edge_sync.sv
// Brings one asynchronous line into the clock domain and flags its rising edges.
// Assumes: the line stays at each level for at least STAGES+1 clocks, so no
// edge is lost. Synchronous active-low reset clears every flop to 0.
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Keep last cycle's synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/burst_gate.sv
// Decides which strobe edges become captures: a burst of BURST_LEN captures,
// then idle until a re-arm edge. Re-arm during a burst is ignored.
// Assumes: edge inputs are single-cycle pulses from edge_sync.
module burst_gate #(
    parameter int BURST_LEN = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_rise_i,
    input  logic rearm_rise_i,
    output logic capture_o,
    output logic last_o
);

    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_LEN - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign capture_o = samp_rise_i & active_q;
    assign last_o    = capture_o & (cnt_q == LAST_CNT);

    // Track burst activity: start armed, stop on last capture, restart on idle re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active_q <= 1'b1;
        else if (last_o)                 active_q <= 1'b0;
        else if (!active_q && rearm_rise_i) active_q <= 1'b1;
    end

    // Count captures within the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (last_o)    cnt_q <= '0;
        else if (capture_o) cnt_q <= cnt_q + 1'b1;
    end

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !samp_rise_i) |=> (active_q && $stable(cnt_q)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !rearm_rise_i) |=> !active_q);

    // R5
    rearm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && rearm_rise_i) |=> (active_q && cnt_q == '0));

endmodule

// File: rtl/ring_ptr.sv
// Write pointer over two banks of BANK_DEPTH words. Advances once per capture,
// flags the bank it leaves, and wraps from the top of bank B to bank A offset 0.
// Assumes: reset is the only way to rewind it.
module ring_ptr
    import burst_pkg::*;
#(
    parameter int BANK_DEPTH = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv_i,
    output logic [$clog2(BANK_DEPTH):0]   addr_o,
    output logic [NUM_BANKS-1:0]          full_o
);

    localparam int OFF_W = $clog2(BANK_DEPTH);
    localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(BANK_DEPTH - 1);

    bank_e            bank_q;
    logic [OFF_W-1:0] off_q;
    logic             at_top;

    assign at_top = (off_q == TOP_OFF);
    assign addr_o = {bank_q, off_q};

    // Per-bank flag for the write landing on the last offset of that bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_full
        assign full_o[b] = adv_i & at_top & (bank_q == bank_e'(b));
    end

    // Step offset, flipping bank at the top of each bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BANK_A;
            off_q  <= '0;
        end else if (adv_i) begin
            if (at_top) begin
                bank_q <= (bank_q == BANK_A) ? BANK_B : BANK_A;
                off_q  <= '0;
            end else begin
                off_q  <= off_q + 1'b1;
            end
        end
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(addr_o));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && bank_q == BANK_B && at_top) |=> (addr_o == '0));

endmodule

// File: rtl/burst_sampler.sv
// Top: synchronizes the strobe and re-arm lines, gates strobe edges into
// bursts, and drives a registered memory write port with bank/burst flags.
// Assumes: data_i is stable for 3 clocks after a strobe rising edge.
module burst_sampler
    import burst_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 256,
    parameter int BURST_LEN  = 192
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          samp_i,
    input  logic                          rearm_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic                          wr_en_o,
    output logic [$clog2(BANK_DEPTH):0]   wr_addr_o,
    output logic [DATA_W-1:0]             wr_data_o,
    output logic [NUM_BANKS-1:0]          bank_full_o,
    output logic                          burst_done_o
);

    localparam int OFF_W  = $clog2(BANK_DEPTH);
    localparam int ADDR_W = OFF_W + 1;
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] rises;
    logic               capture, last;
    logic [ADDR_W-1:0]  cur_addr;
    logic [NUM_BANKS-1:0] cur_full;

    assign raw_lines = {rearm_i, samp_i};

    // One synchronizer and edge detector per asynchronous line.
    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        edge_sync #(.STAGES(2)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_lines[i]),
            .rise_o  (rises[i])
        );
    end

    burst_gate #(.BURST_LEN(BURST_LEN)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_rise_i  (rises[0]),
        .rearm_rise_i (rises[1]),
        .capture_o    (capture),
        .last_o       (last)
    );

    ring_ptr #(.BANK_DEPTH(BANK_DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (capture),
        .addr_o (cur_addr),
        .full_o (cur_full)
    );

    // Register the write port and flags so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o      <= 1'b0;
            wr_addr_o    <= '0;
            wr_data_o    <= '0;
            bank_full_o  <= '0;
            burst_done_o <= 1'b0;
        end else begin
            wr_en_o      <= capture;
            bank_full_o  <= cur_full;
            burst_done_o <= last;
            if (capture) begin
                wr_addr_o <= cur_addr;
                wr_data_o <= data_i;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !burst_done_o && bank_full_o == '0));

    // R4
    done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_o |-> wr_en_o);

    // R7
    full_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_full_o));

    // R7
    full_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full_o != '0) |-> (wr_en_o && wr_addr_o[OFF_W-1:0] == OFF_W'(BANK_DEPTH - 1)));

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

endmodule

// File: tb/sim_burst_sampler.sv
module sim_burst_sampler;

    localparam int DATA_W     = 8;
    localparam int BANK_DEPTH = 256;
    localparam int BURST_LEN  = 192;
    localparam int ADDR_W     = $clog2(BANK_DEPTH) + 1;
    localparam int TOTAL      = 2 * BANK_DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_i = 1'b0;
    logic              rearm_i = 1'b0;
    logic [DATA_W-1:0] data_i = '0;
    logic              wr_en_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [DATA_W-1:0] wr_data_o;
    logic [1:0]        bank_full_o;
    logic              burst_done_o;

    always #5 clk = ~clk;

    burst_sampler #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .BURST_LEN(BURST_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .rearm_i(rearm_i), .data_i(data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .bank_full_o(bank_full_o), .burst_done_o(burst_done_o)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Observed write activity.
    int                nwr = 0, ndone = 0, nfull = 0;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic              last_done;
    logic [1:0]        last_full;

    always @(negedge clk) begin
        if (wr_en_o) begin
            nwr++;
            last_addr = wr_addr_o;
            last_data = wr_data_o;
            last_done = burst_done_o;
            last_full = bank_full_o;
        end
        if (burst_done_o) ndone++;
        if (bank_full_o != 2'b00) nfull++;
    end

    // Reference model state.
    int exp_ptr = 0;
    int exp_cnt = 0;
    bit exp_armed = 1;

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_full_of(int p);
        if ((p % BANK_DEPTH) == BANK_DEPTH - 1) return 1 << (p / BANK_DEPTH);
        return 0;
    endfunction

    function automatic int rand_in(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // One strobe pulse; checks the write it should or should not produce.
    task automatic pulse(int hi, int lo, string tag);
        int n0 = nwr, d0 = ndone, f0 = nfull;
        logic [DATA_W-1:0] d = DATA_W'($urandom);
        @(negedge clk);
        data_i = d;
        samp_i = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk);
        samp_i = 1'b0;
        repeat (lo - 1) @(negedge clk);
        if (exp_armed) begin
            int ef = exp_full_of(exp_ptr);
            bit ed = (exp_cnt == BURST_LEN - 1);
            check(nwr - n0 == 1, {tag, " write count"}, nwr - n0, 1);
            check(int'(last_addr) == exp_ptr, {tag, " R6 address"}, int'(last_addr), exp_ptr);
            check(last_data == d, {tag, " R2 data"}, int'(last_data), int'(d));
            check(last_done == ed && ndone - d0 == int'(ed), {tag, " R4 done"}, ndone - d0, int'(ed));
            check(int'(last_full) == ef && nfull - f0 == int'(ef != 0), {tag, " R7 bank full"},
                  int'(last_full), ef);
            exp_ptr = (exp_ptr + 1) % TOTAL;
            if (ed) begin
                exp_cnt = 0;
                exp_armed = 0;
            end else begin
                exp_cnt++;
            end
        end else begin
            check(nwr == n0 && ndone == d0 && nfull == f0, {tag, " R3 no write when idle"},
                  nwr - n0, 0);
        end
    endtask

    task automatic rearm();
        @(negedge clk);
        rearm_i = 1'b1;
        repeat (4) @(negedge clk);
        rearm_i = 1'b0;
        repeat (4) @(negedge clk);
        if (!exp_armed) begin
            exp_armed = 1;
            exp_cnt = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        samp_i = 1'b0;
        rearm_i = 1'b0;
        repeat (3) @(negedge clk);
        check(!wr_en_o && !burst_done_o && bank_full_o == 2'b00, "R1 outputs quiet in reset",
              int'(wr_en_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en_o && !burst_done_o && bank_full_o == 2'b00, "R1 outputs quiet after reset",
              int'(wr_en_o), 0);
        exp_ptr = 0;
        exp_cnt = 0;
        exp_armed = 1;
    endtask

    task automatic run_burst(string tag);
        for (int i = 0; i < BURST_LEN; i++) pulse(rand_in(3, 6), rand_in(3, 6), tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Burst 1 with directed corners mixed in.
        pulse(3, 3, "R1 first write at address 0");
        pulse(25, 4, "R9 long high strobe");
        for (int i = 2; i < BURST_LEN; i++) begin
            if (i == 100) rearm();                // R8 re-arm during active burst
            pulse(rand_in(3, 6), rand_in(3, 6), "R2 burst1");
        end
        check(!exp_armed, "R8 burst not extended by mid-burst re-arm", exp_cnt, 0);
        for (int i = 0; i < 3; i++) pulse(4, 4, "R3 edges after burst");

        // Burst 2 crosses from bank 0 into bank 1; pointer continues.
        rearm();
        pulse(4, 4, "R5 R6 continue after re-arm");
        for (int i = 1; i < BURST_LEN; i++) pulse(rand_in(3, 6), rand_in(3, 6), "R7 burst2");
        pulse(3, 5, "R3 idle after burst2");

        // Burst 3 fills bank 1 and wraps to address 0.
        rearm();
        run_burst("R7 burst3 wrap");
        rearm();
        rearm();                                  // second re-arm while active: R8
        for (int i = 0; i < 10; i++) pulse(rand_in(3, 6), rand_in(3, 6), "R5 burst4");

        // Reset mid-burst then a fresh full burst from address 0.
        do_reset();
        run_burst("R10 after reset");
        pulse(4, 4, "R10 R3 idle after fresh burst");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule